// File: doc/BRIEF.md
# Read Wait-State Emulation Controller

This controller stretches read completions on a simple request/ready bus so that an overlay memory can reproduce the access timing of a slower memory array. A read picks its own extra latency through a 5-bit field in otherwise unused high address bits, bits 28 down to 24. A lookup that is not monotonic turns that field into a wait-state count. The count is added to a programmable base read wait-state value, and `ready` is held low for the total.

Only the opening beat of a read is stretched, whether it is a single beat or the first beat of a burst. Later sequential beats and all writes complete at once. While a read with a non-zero field is in flight, the block tells the neighbouring line-buffer logic to ignore hits and start no prefetch. It also reports field codes that have no table entry. One request is taken at a time, and only while the controller is idle.

Top module: `rwe_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready`, `buf_bypass`, `pf_block` and `bad_code` are all 0.
- R2: A read with `req_first`=1 that is accepted at a clock edge makes `ready` rise N+1 cycles later. N = `base_ws` + table(code) + (2 if 1 ≤ code ≤ 5, else 0). The code is `req_addr[28:24]`.
- R3: The table gives 0, 10, 18, 26, 3 and 11 wait states for codes 0, 1, 2, 3, 4 and 5.
- R4: A read with `req_first`=0 (a later burst beat) gets no wait states at all, base included. `ready` rises in the cycle right after acceptance.
- R5: A write (`req_write`=1) gets no wait states, whatever the address field and `base_ws` hold.
- R6: For a read with a non-zero code, `buf_bypass` and `pf_block` are 1 from the cycle after acceptance through the `ready` cycle. Both are 0 for code 0 and for writes.
- R7: Codes 6 to 31 add no wait states, not even the fixed 2. For a read with such a code, `bad_code` is 1 from the cycle after acceptance through the `ready` cycle.
- R8: `ready` is high for exactly one cycle per accepted request.
- R9: A request presented while the controller is busy is ignored. It yields no `ready` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_addr | input | 32 | Access address; bits 28:24 select emulated timing |
| req_write | input | 1 | 1 = write, 0 = read |
| req_first | input | 1 | 1 = single beat or first burst beat, 0 = sequential beat |
| base_ws | input | 4 | Programmed base read wait states |
| ready | output | 1 | One-cycle completion strobe |
| buf_bypass | output | 1 | Line-buffer hits must be ignored |
| pf_block | output | 1 | No line prefetch may be started |
| bad_code | output | 1 | Read used an address code without a table entry |

## Verification
Every cycle, the assertions check these properties: `ready` is a single-cycle strobe, and sequential beats and writes complete on the very next cycle. They also check that the bypass, prefetch-block and bad-code flags come up after a qualifying read is accepted, and that no flag is raised while the controller is idle. Other behaviour can only be shown by the bench scenarios. These scenarios cover the exact stretch length for each table code under different base values, including the largest total. They also cover codes without a table entry, and a request made during a long stretch that must leave no trace.

// File: rtl/rwe_pkg.sv
package rwe_pkg;

    localparam int FIELD_W   = 5;
    localparam int EXTRA_W   = 5;
    localparam int MAX_EXTRA = 28;
    localparam int FIXED_ADD = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } rwe_state_e;

    typedef struct packed {
        logic [EXTRA_W-1:0] waits;
        logic               unsupported;
        logic               nonzero;
    } rwe_lookup_t;

    typedef struct packed {
        logic bypass;
        logic bad;
    } rwe_flags_t;

    function automatic rwe_lookup_t emu_lookup(input logic [FIELD_W-1:0] code);
        rwe_lookup_t r;
        r.nonzero     = (code != '0);
        r.unsupported = 1'b0;
        unique case (code)
            5'd0:    r.waits = EXTRA_W'(0);
            5'd1:    r.waits = EXTRA_W'(10 + FIXED_ADD);
            5'd2:    r.waits = EXTRA_W'(18 + FIXED_ADD);
            5'd3:    r.waits = EXTRA_W'(26 + FIXED_ADD);
            5'd4:    r.waits = EXTRA_W'(3 + FIXED_ADD);
            5'd5:    r.waits = EXTRA_W'(11 + FIXED_ADD);
            default: begin
                r.waits       = EXTRA_W'(0);
                r.unsupported = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rwe_decode.sv
module rwe_decode
    import rwe_pkg::*;
(
    input  logic [FIELD_W-1:0] code,
    output logic [EXTRA_W-1:0] extra,
    output logic               unsupported,
    output logic               nonzero
);
    rwe_lookup_t lk;

    always_comb begin
        lk          = emu_lookup(code);
        extra       = lk.waits;
        unsupported = lk.unsupported;
        nonzero     = lk.nonzero;
    end
endmodule

// File: rtl/rwe_timer.sv
module rwe_timer
    import rwe_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle,
    output logic             done
);
    rwe_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (load) begin
                        if (load_val == '0) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_WAIT;
                            cnt   <= load_val;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_DONE;
                    end
                    cnt <= cnt - CNT_W'(1);
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle = (state == ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/rwe_ctrl.sv
module rwe_ctrl
    import rwe_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int FIELD_LO = 24,
    parameter int BASE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_first,
    input  logic [BASE_W-1:0] base_ws,
    output logic              ready,
    output logic              buf_bypass,
    output logic              pf_block,
    output logic              bad_code
);
    localparam int MAX_TOTAL = (1 << BASE_W) - 1 + MAX_EXTRA;
    localparam int CNT_W     = $clog2(MAX_TOTAL + 1);

    logic [FIELD_W-1:0] code;
    logic [EXTRA_W-1:0] extra;
    logic               unsupported;
    logic               nonzero;
    logic               is_read;
    logic               stretch;
    logic [CNT_W-1:0]   latency;
    logic               idle;
    logic               done;
    logic               accept;
    rwe_flags_t         flags_q;
    rwe_flags_t         flags_d;

    assign code = req_addr[FIELD_LO +: FIELD_W];

    rwe_decode u_decode (
        .code        (code),
        .extra       (extra),
        .unsupported (unsupported),
        .nonzero     (nonzero)
    );

    assign is_read = !req_write;
    assign stretch = is_read && req_first;
    assign latency = stretch ? (CNT_W'(base_ws) + CNT_W'(extra)) : '0;
    assign accept  = req_valid && idle;

    rwe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (latency),
        .idle     (idle),
        .done     (done)
    );

    always_comb begin
        flags_d.bypass = is_read && nonzero;
        flags_d.bad    = is_read && unsupported;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (accept) begin
            flags_q <= flags_d;
        end else if (done) begin
            flags_q <= '0;
        end
    end

    assign ready      = done;
    assign buf_bypass = flags_q.bypass;
    assign pf_block   = flags_q.bypass;
    assign bad_code   = flags_q.bad;
endmodule

// File: rtl/rwe_ctrl_chk.sv
module rwe_ctrl_chk #(
    parameter int ADDR_W   = 32,
    parameter int FIELD_LO = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_first,
    input logic              accept,
    input logic              idle,
    input logic              ready,
    input logic              buf_bypass,
    input logic              pf_block,
    input logic              bad_code
);
    logic [4:0] code_c;
    assign code_c = req_addr[FIELD_LO +: 5];

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    assert_seq_beat_fast_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !req_first) |=> ready);

    assert_write_fast_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write) |=> ready);

    assert_bypass_set_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && code_c != 5'd0) |=> (buf_bypass && pf_block));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!buf_bypass && !pf_block && !bad_code));

    assert_bad_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && code_c > 5'd5) |=> bad_code);
endmodule

bind rwe_ctrl rwe_ctrl_chk #(.ADDR_W(ADDR_W), .FIELD_LO(FIELD_LO)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_first  (req_first),
    .accept     (accept),
    .idle       (idle),
    .ready      (ready),
    .buf_bypass (buf_bypass),
    .pf_block   (pf_block),
    .bad_code   (bad_code)
);

// File: tb/sim_rwe_ctrl.sv
module sim_rwe_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_first = 1'b1;
    logic [3:0]  base_ws = '0;
    logic        ready, buf_bypass, pf_block, bad_code;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        int lat;
        bit byp;
        bit bad;
        string tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rwe_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_first(req_first), .base_ws(base_ws),
        .ready(ready), .buf_bypass(buf_bypass), .pf_block(pf_block),
        .bad_code(bad_code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int table_waits(input int code);
        case (code)
            0: return 0;
            1: return 12;
            2: return 20;
            3: return 28;
            4: return 5;
            5: return 13;
            default: return 0;
        endcase
    endfunction

    task automatic do_req(input int code, input bit wr, input bit first,
                          input int base, input string tag, input bit poke);
        exp_t e;
        @(negedge clk);
        req_addr  = {3'b000, 5'(code), 24'h00A5C0};
        req_write = wr;
        req_first = first;
        base_ws   = 4'(base);
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        e.lat = (wr || !first) ? 0 : base + table_waits(code);
        e.byp = !wr && (code != 0);
        e.bad = !wr && (code > 5);
        e.tag = tag;
        q.push_back(e);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_addr  = 32'h0000_0040;
            req_write = 1'b1;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (q.size() != 0) begin
                    cyc++;
                    check(buf_bypass == q[0].byp, {q[0].tag, " R6 bypass"}, buf_bypass, q[0].byp);
                    check(pf_block == q[0].byp, {q[0].tag, " R6 prefetch"}, pf_block, q[0].byp);
                    check(bad_code == q[0].bad, {q[0].tag, " R7 bad"}, bad_code, q[0].bad);
                    if (ready) begin
                        check(cyc == q[0].lat + 1, {q[0].tag, " latency"}, cyc, q[0].lat + 1);
                        void'(q.pop_front());
                        cyc = 0;
                    end else if (cyc > 60) begin
                        check(0, {q[0].tag, " no ready"}, cyc, q[0].lat + 1);
                        void'(q.pop_front());
                        cyc = 0;
                    end
                end else begin
                    check(ready == 0, "idle R8 R9 ready", ready, 0);
                    check(buf_bypass == 0 && bad_code == 0, "idle R9 flags", buf_bypass, 0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ready == 0 && buf_bypass == 0 && pf_block == 0 && bad_code == 0,
              "R1 reset outputs", ready, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 0 && buf_bypass == 0 && bad_code == 0, "R1 after reset", ready, 0);

        do_req(0, 0, 1, 0,  "R2 code0 base0", 0);
        do_req(0, 0, 1, 5,  "R2 code0 base5", 0);
        do_req(1, 0, 1, 2,  "R3 code1", 0);
        do_req(2, 0, 1, 2,  "R3 code2", 0);
        do_req(3, 0, 1, 2,  "R3 code3", 0);
        do_req(4, 0, 1, 2,  "R3 code4", 0);
        do_req(5, 0, 1, 2,  "R3 code5", 0);
        do_req(3, 0, 1, 15, "R2 max total", 0);
        do_req(3, 0, 0, 9,  "R4 seq beat", 0);
        do_req(0, 0, 0, 7,  "R4 seq beat code0", 0);
        do_req(2, 1, 1, 12, "R5 write code2", 0);
        do_req(0, 1, 0, 3,  "R5 write seq", 0);
        do_req(7, 0, 1, 4,  "R7 code7", 0);
        do_req(31, 0, 1, 0, "R7 code31", 0);
        do_req(6, 1, 1, 0,  "R5 write code6", 0);
        do_req(1, 0, 1, 6,  "R9 busy poke", 1);
        do_req(4, 0, 1, 1,  "R8 after poke", 0);
        repeat (5) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule